// File: doc/BRIEF.md
# Four-Segment Floating-Point Add/Subtract Pipeline

This block adds or subtracts two floating-point operands, each written as a sign, an unsigned magnitude fraction and a biased exponent. The value of an operand is (-1)^sign x (magnitude / 2^MW) x 2^exponent, so the top magnitude bit weighs one half. The work is split into four segments, and each segment ends in a register. Segment one finds the exponent difference by subtraction and orders the operands by exponent. Segment two aligns the mantissa of the smaller-exponent operand. Segment three forms the signed-magnitude sum or difference. Segment four normalises the result and corrects the exponent.

Operands enter and results leave on valid/ready streams. The block takes one operation per clock while the output is drained. It stalls as a whole when a finished result is held back. An input transfer happens on a rising edge where `in_valid` and `in_ready` are both high. An output transfer happens where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the last segment is empty or its result is being taken in that cycle. While `out_valid` is high and `out_ready` is low, the result on the output holds steady and no new operand is taken. Special values, rounding modes and exception flags are not handled. Exponent arithmetic wraps modulo 2^EW and has no range detection.

Top module: `fpadd4_pipe`

## Requirements
- R1: The result exponent before normalisation is the larger of the two input exponents. When the exponents are equal, operand A is treated as the larger one.
- R2: The mantissa of the smaller-exponent operand is shifted right by the exponent difference, and the bits shifted out are dropped (truncation).
- R3: When the exponent difference is MW or more, the aligned mantissa of the smaller operand is zero.
- R4: `in_op` = 1 selects subtraction by inverting the sign of operand B. `in_op` = 0 selects addition.
- R5: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller one, and it takes the sign of the larger magnitude. When the two aligned magnitudes are equal, A's sign is used.
- R6: A carry out of the magnitude sum shifts the magnitude right by one and raises the exponent by one.
- R7: A nonzero result with k leading zeros is shifted left by k, and the exponent is lowered by k.
- R8: A zero result magnitude is delivered with exponent 0 and sign 0.
- R9: A result appears on the output four clock edges after its operand is accepted. Results come out in acceptance order, and one operand per clock is accepted while `out_ready` stays high.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value, and no result is lost.
- R11: A synchronous active-high `rst` empties the pipeline, so `out_valid` is low after the next edge.
- R12: Every valid nonzero result has its top magnitude bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pipeline can take an operand pair |
| in_op | input | 1 | 0 add, 1 subtract (A - B) |
| a_sign | input | 1 | Sign of A |
| a_mag | input | MW | Magnitude fraction of A |
| a_exp | input | EW | Biased exponent of A |
| b_sign | input | 1 | Sign of B |
| b_mag | input | MW | Magnitude fraction of B |
| b_exp | input | EW | Biased exponent of B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Result sign |
| out_mag | output | MW | Normalised result magnitude |
| out_exp | output | EW | Result exponent |

## Verification
The operand table covers several input patterns, and each one separates a different path through the datapath. Equal exponents with a carry separate the right-normalise path from the others. Partial cancellations, with shallow and deep leading zeros, exercise the left-normalise path. Exact cancellation exercises the zero path. Exponent gaps of 2, 7, 8 and 10 separate plain alignment from full flush. Cases where B has the larger exponent show whether the operand swap happens. Subtractions of negative operands, and cases where the smaller-exponent operand has the larger magnitude, show whether the sign comes from the correct operand. Directed runs then measure the four-edge latency, hold the output back to check stalling and ordering, and apply reset.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpa_op_e;
endpackage

// File: rtl/fpa_seg_cmp.sv
module fpa_seg_cmp #(
  parameter int MW = 8,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          i_valid,
  input  logic          i_op,
  input  logic          i_as,
  input  logic [MW-1:0] i_am,
  input  logic [EW-1:0] i_ae,
  input  logic          i_bs,
  input  logic [MW-1:0] i_bm,
  input  logic [EW-1:0] i_be,
  output logic          o_valid,
  output logic          o_big_s,
  output logic [MW-1:0] o_big_m,
  output logic          o_sml_s,
  output logic [MW-1:0] o_sml_m,
  output logic [EW-1:0] o_exp,
  output logic [EW-1:0] o_dist
);
  import fpa_pkg::*;

  logic [EW:0]   diff;
  logic          a_ge;
  logic          b_eff_s;
  logic [EW-1:0] dist_c;

  always_comb begin
    diff    = {1'b0, i_ae} - {1'b0, i_be};
    a_ge    = ~diff[EW];
    b_eff_s = i_bs ^ (fpa_op_e'(i_op) == OP_SUB);
    dist_c  = a_ge ? diff[EW-1:0] : (i_be - i_ae);
  end

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else if (adv) o_valid <= i_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      o_big_s <= a_ge ? i_as : b_eff_s;
      o_big_m <= a_ge ? i_am : i_bm;
      o_sml_s <= a_ge ? b_eff_s : i_as;
      o_sml_m <= a_ge ? i_bm : i_am;
      o_exp   <= a_ge ? i_ae : i_be;
      o_dist  <= dist_c;
    end
  end
endmodule

// File: rtl/fpa_seg_align.sv
module fpa_seg_align #(
  parameter int MW = 8,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          i_valid,
  input  logic          i_big_s,
  input  logic [MW-1:0] i_big_m,
  input  logic          i_sml_s,
  input  logic [MW-1:0] i_sml_m,
  input  logic [EW-1:0] i_exp,
  input  logic [EW-1:0] i_dist,
  output logic          o_valid,
  output logic          o_big_s,
  output logic [MW-1:0] o_big_m,
  output logic          o_sml_s,
  output logic [MW-1:0] o_al_m,
  output logic [EW-1:0] o_exp
);
  localparam int SW = (MW > 1) ? $clog2(MW) : 1;

  logic [MW-1:0] stage [0:SW];
  logic          far;

  assign stage[0] = i_sml_m;

  for (genvar k = 0; k < SW; k++) begin : g_shift
    assign stage[k+1] = i_dist[k] ? (stage[k] >> (1 << k)) : stage[k];
  end

  assign far = (int'(i_dist) >= MW);

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else if (adv) o_valid <= i_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      o_big_s <= i_big_s;
      o_big_m <= i_big_m;
      o_sml_s <= i_sml_s;
      o_al_m  <= far ? '0 : stage[SW];
      o_exp   <= i_exp;
    end
  end
endmodule

// File: rtl/fpa_seg_addsub.sv
module fpa_seg_addsub #(
  parameter int MW = 8,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          i_valid,
  input  logic          i_big_s,
  input  logic [MW-1:0] i_big_m,
  input  logic          i_sml_s,
  input  logic [MW-1:0] i_al_m,
  input  logic [EW-1:0] i_exp,
  output logic          o_valid,
  output logic          o_s,
  output logic [MW:0]   o_m,
  output logic [EW-1:0] o_exp
);
  logic          res_s;
  logic [MW:0]   res_m;

  always_comb begin
    if (i_big_s == i_sml_s) begin
      res_m = {1'b0, i_big_m} + {1'b0, i_al_m};
      res_s = i_big_s;
    end else if (i_big_m >= i_al_m) begin
      res_m = {1'b0, i_big_m - i_al_m};
      res_s = i_big_s;
    end else begin
      res_m = {1'b0, i_al_m - i_big_m};
      res_s = i_sml_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else if (adv) o_valid <= i_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      o_s   <= res_s;
      o_m   <= res_m;
      o_exp <= i_exp;
    end
  end
endmodule

// File: rtl/fpa_seg_norm.sv
module fpa_seg_norm #(
  parameter int MW = 8,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          i_valid,
  input  logic          i_s,
  input  logic [MW:0]   i_m,
  input  logic [EW-1:0] i_exp,
  output logic          o_valid,
  output logic          o_s,
  output logic [MW-1:0] o_m,
  output logic [EW-1:0] o_exp
);
  localparam int LZW = $clog2(MW + 1);

  logic [LZW-1:0] lz;
  logic           n_s;
  logic [MW-1:0]  n_m;
  logic [EW-1:0]  n_exp;

  always_comb begin
    lz = LZW'(MW);
    for (int i = 0; i < MW; i++) begin
      if (i_m[i]) lz = LZW'(MW - 1 - i);
    end
  end

  always_comb begin
    if (i_m[MW]) begin
      n_m   = i_m[MW:1];
      n_exp = i_exp + EW'(1);
      n_s   = i_s;
    end else if (i_m == '0) begin
      n_m   = '0;
      n_exp = '0;
      n_s   = 1'b0;
    end else begin
      n_m   = i_m[MW-1:0] << lz;
      n_exp = i_exp - EW'(lz);
      n_s   = i_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else if (adv) o_valid <= i_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      o_s   <= n_s;
      o_m   <= n_m;
      o_exp <= n_exp;
    end
  end
endmodule

// File: rtl/fpadd4_pipe.sv
module fpadd4_pipe #(
  parameter int MW = 8,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_op,
  input  logic          a_sign,
  input  logic [MW-1:0] a_mag,
  input  logic [EW-1:0] a_exp,
  input  logic          b_sign,
  input  logic [MW-1:0] b_mag,
  input  logic [EW-1:0] b_exp,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sign,
  output logic [MW-1:0] out_mag,
  output logic [EW-1:0] out_exp
);
  logic          adv;

  logic          v1, big_s1, sml_s1;
  logic [MW-1:0] big_m1, sml_m1;
  logic [EW-1:0] exp1, dist1;

  logic          v2, big_s2, sml_s2;
  logic [MW-1:0] big_m2, al_m2;
  logic [EW-1:0] exp2;

  logic          v3, s3;
  logic [MW:0]   m3;
  logic [EW-1:0] exp3;

  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;

  fpa_seg_cmp #(.MW(MW), .EW(EW)) u_cmp (
    .clk(clk), .rst(rst), .adv(adv), .i_valid(in_valid), .i_op(in_op),
    .i_as(a_sign), .i_am(a_mag), .i_ae(a_exp),
    .i_bs(b_sign), .i_bm(b_mag), .i_be(b_exp),
    .o_valid(v1), .o_big_s(big_s1), .o_big_m(big_m1),
    .o_sml_s(sml_s1), .o_sml_m(sml_m1), .o_exp(exp1), .o_dist(dist1)
  );

  fpa_seg_align #(.MW(MW), .EW(EW)) u_align (
    .clk(clk), .rst(rst), .adv(adv), .i_valid(v1),
    .i_big_s(big_s1), .i_big_m(big_m1), .i_sml_s(sml_s1), .i_sml_m(sml_m1),
    .i_exp(exp1), .i_dist(dist1),
    .o_valid(v2), .o_big_s(big_s2), .o_big_m(big_m2),
    .o_sml_s(sml_s2), .o_al_m(al_m2), .o_exp(exp2)
  );

  fpa_seg_addsub #(.MW(MW), .EW(EW)) u_addsub (
    .clk(clk), .rst(rst), .adv(adv), .i_valid(v2),
    .i_big_s(big_s2), .i_big_m(big_m2), .i_sml_s(sml_s2), .i_al_m(al_m2),
    .i_exp(exp2),
    .o_valid(v3), .o_s(s3), .o_m(m3), .o_exp(exp3)
  );

  fpa_seg_norm #(.MW(MW), .EW(EW)) u_norm (
    .clk(clk), .rst(rst), .adv(adv), .i_valid(v3),
    .i_s(s3), .i_m(m3), .i_exp(exp3),
    .o_valid(out_valid), .o_s(out_sign), .o_m(out_mag), .o_exp(out_exp)
  );
endmodule

// File: rtl/fpadd4_pipe_chk.sv
module fpadd4_pipe_chk #(
  parameter int MW = 8,
  parameter int EW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_sign,
  input logic [MW-1:0] out_mag,
  input logic [EW-1:0] out_exp
);
  assert_normalised_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mag != '0) |-> out_mag[MW-1]);

  assert_zero_clean_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mag == '0) |-> (out_exp == '0 && !out_sign));

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mag)
                                   && $stable(out_exp) && $stable(out_sign)));

  assert_no_intake_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_reset_empty_R11: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind fpadd4_pipe fpadd4_pipe_chk #(.MW(MW), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sign(out_sign), .out_mag(out_mag),
  .out_exp(out_exp)
);

// File: tb/sim_fpadd4_pipe.sv
module sim_fpadd4_pipe;
  localparam int MW = 8;
  localparam int EW = 6;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_op = 1'b0;
  logic          a_sign = 1'b0, b_sign = 1'b0;
  logic [MW-1:0] a_mag = '0, b_mag = '0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic          out_ready = 1'b1;
  logic          in_ready, out_valid, out_sign;
  logic [MW-1:0] out_mag;
  logic [EW-1:0] out_exp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int waits  = 0;

  logic [14:0] expq[$];
  string       tagq[$];

  always #5 clk = ~clk;

  fpadd4_pipe #(.MW(MW), .EW(EW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .a_sign(a_sign), .a_mag(a_mag), .a_exp(a_exp),
    .b_sign(b_sign), .b_mag(b_mag), .b_exp(b_exp),
    .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
    .out_mag(out_mag), .out_exp(out_exp)
  );

  // {op, as, am, ae, bs, bm, be, rs, rm, re}
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h80, 6'd5,  1'b0, 8'h80, 6'd5,  1'b0, 8'h80, 6'd6},
    {1'b0, 1'b0, 8'hC0, 6'd4,  1'b0, 8'h80, 6'd2,  1'b0, 8'hE0, 6'd4},
    {1'b1, 1'b0, 8'hC0, 6'd3,  1'b0, 8'h80, 6'd3,  1'b0, 8'h80, 6'd2},
    {1'b1, 1'b0, 8'h80, 6'd2,  1'b0, 8'hC0, 6'd2,  1'b1, 8'h80, 6'd1},
    {1'b0, 1'b1, 8'h90, 6'd7,  1'b1, 8'h90, 6'd7,  1'b1, 8'h90, 6'd8},
    {1'b0, 1'b0, 8'hA0, 6'd20, 1'b0, 8'hFF, 6'd12, 1'b0, 8'hA0, 6'd20},
    {1'b0, 1'b0, 8'h80, 6'd10, 1'b0, 8'hFF, 6'd3,  1'b0, 8'h81, 6'd10},
    {1'b1, 1'b0, 8'h55, 6'd9,  1'b0, 8'h55, 6'd9,  1'b0, 8'h00, 6'd0},
    {1'b0, 1'b0, 8'h80, 6'd1,  1'b0, 8'h80, 6'd4,  1'b0, 8'h90, 6'd4},
    {1'b1, 1'b0, 8'hF0, 6'd3,  1'b0, 8'h80, 6'd4,  1'b1, 8'h80, 6'd0},
    {1'b0, 1'b0, 8'h01, 6'd10, 1'b0, 8'h00, 6'd0,  1'b0, 8'h80, 6'd3},
    {1'b1, 1'b1, 8'h80, 6'd5,  1'b1, 8'hA0, 6'd5,  1'b0, 8'h80, 6'd3}
  };

  string tags [NV];
  initial begin
    tags[0]  = "R6 carry renormalise";
    tags[1]  = "R1 R2 align by 2";
    tags[2]  = "R4 R7 subtract equal exp";
    tags[3]  = "R5 R4 larger magnitude sign";
    tags[4]  = "R6 negative carry";
    tags[5]  = "R3 gap equals width";
    tags[6]  = "R2 gap 7 truncation";
    tags[7]  = "R8 exact cancel";
    tags[8]  = "R1 B larger exponent";
    tags[9]  = "R7 R5 deep cancel";
    tags[10] = "R7 R3 unnormalised input";
    tags[11] = "R5 R4 negative minus negative";
  end

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // Drive one operand pair; inputs change just after a rising edge.
  task automatic send(input int idx);
    logic [45:0] v;
    v = VEC[idx];
    in_op  = v[45];
    a_sign = v[44]; a_mag = v[43:36]; a_exp = v[35:30];
    b_sign = v[29]; b_mag = v[28:21]; b_exp = v[20:15];
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) begin
      waits++;
      @(negedge clk);
    end
    expq.push_back(v[14:0]);
    tagq.push_back(tags[idx]);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // Output monitor: compares every transfer with the next expected result.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid && out_ready) begin
        logic [14:0] e;
        string t;
        if (expq.size() == 0) begin
          check(1'b0, "R9 unexpected output", $sformatf("%h", {out_sign, out_mag, out_exp}), "none");
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          check({out_sign, out_mag, out_exp} == e, t,
                $sformatf("s=%0d m=%h e=%0d", out_sign, out_mag, out_exp),
                $sformatf("s=%0d m=%h e=%0d", e[14], e[13:6], e[5:0]));
        end
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        check(1'b0, "watchdog", "hung", "finish");
        summary_and_end();
      end
    end
  end

  initial begin
    int n;
    logic [14:0] held;

    // Reset state (R11)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid in reset", $sformatf("%0d", out_valid), "0");
    check(in_ready == 1'b1, "R11 in_ready in reset", $sformatf("%0d", in_ready), "1");
    @(posedge clk); #1;
    rst = 1'b0;

    // Latency (R9): single operation, count edges to output
    send(0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out_valid && n < 10);
    check(n == 4, "R9 latency", $sformatf("%0d", n), "4");
    repeat (2) @(posedge clk); #1;

    // Table streamed back to back (R1-R8 checked by monitor, R9 throughput)
    waits = 0;
    for (int i = 0; i < NV; i++) send(i);
    check(waits == 0, "R9 one per clock", $sformatf("%0d stalls", waits), "0 stalls");
    repeat (8) @(posedge clk); #1;
    check(expq.size() == 0, "R9 all results out", $sformatf("%0d left", expq.size()), "0 left");

    // Back-pressure (R10)
    out_ready = 1'b0;
    send(1);
    send(3);
    send(7);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(out_valid && !in_ready, "R10 stall state",
          $sformatf("v=%0d r=%0d", out_valid, in_ready), "v=1 r=0");
    held = {out_sign, out_mag, out_exp};
    repeat (5) @(negedge clk);
    check({out_sign, out_mag, out_exp} == held && out_valid, "R10 output held",
          $sformatf("%h", {out_sign, out_mag, out_exp}), $sformatf("%h", held));
    check(!in_ready, "R10 no intake while held", $sformatf("%0d", in_ready), "0");
    @(posedge clk); #1;
    out_ready = 1'b1;
    repeat (6) @(posedge clk); #1;
    check(expq.size() == 0, "R10 no loss after release", $sformatf("%0d left", expq.size()), "0 left");

    // Reset while busy (R11)
    send(4);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R11 reset empties", $sformatf("%0d", out_valid), "0");
    expq.delete();
    tagq.delete();
    repeat (6) @(negedge clk);
    check(!out_valid, "R11 nothing emerges after reset", $sformatf("%0d", out_valid), "0");

    summary_and_end();
  end
endmodule